// File: doc/BRIEF.md
# AAL1 Unstructured Cell Segmenter

This block turns the constant-bit-rate byte stream of one TDM port into ATM cells for one virtual circuit. Arriving bytes are packed into 47-byte payload blocks. Each block gets a one-byte AAL1 header and a 6-byte cell header in front of it, making a 54-byte cell. The cell header is taken from a configuration word. The AAL1 header carries a protected 3-bit sequence count. Once the circuit is enabled and the header is configured, no processor action is needed.

Payload storage has two banks. The TDM side keeps filling one bank while the other is sent. Cells leave as 27 sixteen-bit words on a cell-transfer interface. That interface has a start-of-cell strobe, an odd parity bit and a ready handshake from the downstream side.

Top module: `aal1_udt_segmenter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `tx_valid` and `tx_overrun` are 0.
- R2: A cell starts only after 47 bytes have been accepted into a bank. Cell bytes 7 to 53 are those 47 bytes, in their order of arrival.
- R3: A cell is 27 words. Within a word, the earlier byte is in bits [15:8] and the later byte in bits [7:0]. Bytes 0 to 5 are `cfg_hdr` with its most significant byte first. Byte 6 is the AAL1 header.
- R4: The AAL1 header byte holds, from bit 7 down to bit 0: a 0 bit; the 3-bit sequence count in bits [6:4]; in bits [3:1], the remainder of the four bits [7:4] times x^3 divided by x^3+x+1; and in bit 0, a bit that gives the whole byte even parity.
- R5: The sequence count is 0 in the first cell after enabling. It rises by one per cell and wraps from 7 to 0.
- R6: `tx_soc` is 1 on the first word of a cell and 0 on every other word.
- R7: While `tx_valid` is 1, `tx_data` and `tx_par` together hold an odd number of ones.
- R8: A word is taken only on a cycle where `tx_valid` and `tx_ready` are both 1. While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data`, `tx_soc` and `tx_par` hold their values. A started cell is always finished.
- R9: Bytes keep being accepted into the free bank while a cell is being sent. A byte that arrives when both banks are full is dropped, and `tx_overrun` is 1 in the following cycle for that byte.
- R10: While `cfg_enable` is 0, the block ignores incoming bytes, discards any partly filled block, starts no new cell and holds the sequence count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Circuit enable |
| cfg_hdr | input | 48 | Cell header bytes, first byte in the top bits |
| tdm_valid | input | 1 | A TDM byte is present |
| tdm_byte | input | 8 | TDM data byte |
| tx_ready | input | 1 | Downstream can take a word this cycle |
| tx_valid | output | 1 | A cell word is on `tx_data` |
| tx_data | output | 16 | Cell word |
| tx_soc | output | 1 | First word of a cell |
| tx_par | output | 1 | Odd parity bit over `tx_data` |
| tx_overrun | output | 1 | A byte was dropped in the previous cycle |

## Verification
The hardest state to reach is the one where both banks are full. A cell has started and is stalled, and the next block has already been completed behind it. To get there, the bench holds `tx_ready` low from the first word of a cell and feeds three more blocks' worth of bytes. The last 47 bytes carry a marker value that must never appear in a cell. The bench then counts one `tx_overrun` pulse per marker byte. When the output is released, it expects the ramp to continue with no gap. The sequence-count reset uses a similar trick: a partial block of marker bytes is left in the buffer before the circuit is disabled.

// File: rtl/aal1_seg_pkg.sv
package aal1_seg_pkg;

    localparam int PAY_BYTES      = 47;
    localparam int CELL_HDR_BYTES = 6;

    // AAL1 header byte: {0, seq[2:0], crc[2:0], even parity}
    function automatic logic [7:0] aal1_hdr_byte(input logic [2:0] seq);
        logic [3:0] msg;
        logic [2:0] rem;
        logic       fb;
        logic [6:0] top;
        msg = {1'b0, seq};
        rem = 3'b000;
        for (int i = 3; i >= 0; i--) begin
            fb  = msg[i] ^ rem[2];
            rem = {rem[1:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
        end
        top = {msg, rem};
        return {top, ^top};
    endfunction

endpackage

// File: rtl/aal1_pp_buf.sv
module aal1_pp_buf #(
    parameter int BLK_BYTES = 47,
    localparam int IDXW = $clog2(BLK_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  wr_vld_i,
    input  logic [7:0]            wr_byte_i,
    input  logic [1:0][IDXW-1:0]  rd_addr_i,
    output logic [1:0][7:0]       rd_byte_o,
    output logic                  blk_rdy_o,
    input  logic                  rel_i,
    output logic                  ovr_o
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(BLK_BYTES - 1);

    typedef struct packed {
        logic            wr_bank;
        logic [IDXW-1:0] wr_idx;
        logic [1:0]      full;
        logic            rd_bank;
        logic            ovr;
    } buf_st_t;

    buf_st_t q, d;
    logic    wr_en;
    logic [7:0] mem_q [2][BLK_BYTES];

    always_comb begin
        d     = q;
        d.ovr = 1'b0;
        wr_en = 1'b0;
        if (rel_i) begin
            d.full[q.rd_bank] = 1'b0;
            d.rd_bank         = ~q.rd_bank;
        end
        if (!en_i) begin
            d.wr_idx = '0;
        end else if (wr_vld_i) begin
            if (q.full[q.wr_bank]) begin
                d.ovr = 1'b1;
            end else begin
                wr_en = 1'b1;
                if (q.wr_idx == LAST_IDX) begin
                    d.wr_idx          = '0;
                    d.full[q.wr_bank] = 1'b1;
                    d.wr_bank         = ~q.wr_bank;
                end else begin
                    d.wr_idx = q.wr_idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[q.wr_bank][q.wr_idx] <= wr_byte_i;
    end

    for (genvar l = 0; l < 2; l++) begin : g_rd
        always_comb begin
            if (int'(rd_addr_i[l]) < BLK_BYTES)
                rd_byte_o[l] = mem_q[q.rd_bank][rd_addr_i[l]];
            else
                rd_byte_o[l] = 8'h00;
        end
    end

    assign blk_rdy_o = q.full[q.rd_bank];
    assign ovr_o     = q.ovr;

    // R9
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && wr_vld_i && q.full[q.wr_bank] |=> ovr_o);

    // R2
    release_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i |-> q.full[q.rd_bank]);

endmodule

// File: rtl/aal1_cell_tx.sv
module aal1_cell_tx
    import aal1_seg_pkg::*;
#(
    parameter int BLK_BYTES = 47,
    parameter int HDR_BYTES = 6,
    localparam int IDXW  = $clog2(BLK_BYTES),
    localparam int CELL  = HDR_BYTES + 1 + BLK_BYTES,
    localparam int WORDS = CELL / 2,
    localparam int WW    = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_i,
    input  logic [8*HDR_BYTES-1:0] hdr_i,
    input  logic                   blk_rdy_i,
    output logic [1:0][IDXW-1:0]   rd_addr_o,
    input  logic [1:0][7:0]        rd_byte_i,
    output logic                   rel_o,
    input  logic                   tx_ready_i,
    output logic                   tx_valid_o,
    output logic [15:0]            tx_data_o,
    output logic                   tx_soc_o,
    output logic                   tx_par_o
);

    localparam logic [WW-1:0] LAST_W = WW'(WORDS - 1);

    typedef struct packed {
        logic          busy;
        logic [WW-1:0] widx;
        logic [2:0]    seq;
    } tx_st_t;

    tx_st_t q, d;
    logic [1:0][7:0] lane_byte;
    logic [7:0]      aal1_b;

    assign aal1_b = aal1_hdr_byte(q.seq);

    always_comb begin
        d     = q;
        rel_o = 1'b0;
        if (!q.busy) begin
            if (!en_i) begin
                d.seq = 3'd0;
            end else if (blk_rdy_i) begin
                d.busy = 1'b1;
                d.widx = '0;
            end
        end else if (tx_ready_i) begin
            if (q.widx == LAST_W) begin
                d.busy = 1'b0;
                d.seq  = q.seq + 3'd1;
                rel_o  = 1'b1;
            end else begin
                d.widx = q.widx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [WW:0] k;
        int          sh;
        assign k = {q.widx, 1'(l)};
        always_comb begin
            sh           = 8 * (HDR_BYTES - 1 - int'(k));
            rd_addr_o[l] = IDXW'(int'(k) - (HDR_BYTES + 1));
            if (int'(k) < HDR_BYTES)       lane_byte[l] = hdr_i[sh +: 8];
            else if (int'(k) == HDR_BYTES) lane_byte[l] = aal1_b;
            else                           lane_byte[l] = rd_byte_i[l];
        end
    end

    assign tx_valid_o = q.busy;
    assign tx_data_o  = {lane_byte[0], lane_byte[1]};
    assign tx_par_o   = ~^tx_data_o;
    assign tx_soc_o   = q.busy && (q.widx == '0);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && !tx_ready_i |=> q.busy && $stable(tx_data_o) && $stable(q.widx));

    // R6
    soc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc_o && tx_ready_i |=> !tx_soc_o);

    // R5
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.seq) |-> (q.seq == $past(q.seq) + 3'd1) || (q.seq == 3'd0));

    // R10
    no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i && !q.busy |=> !q.busy);

endmodule

// File: rtl/aal1_udt_segmenter.sv
module aal1_udt_segmenter #(
    parameter int BLK_BYTES = aal1_seg_pkg::PAY_BYTES,
    parameter int HDR_BYTES = aal1_seg_pkg::CELL_HDR_BYTES,
    localparam int IDXW  = $clog2(BLK_BYTES),
    localparam int HDR_W = 8 * HDR_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [HDR_W-1:0] cfg_hdr,
    input  logic             tdm_valid,
    input  logic [7:0]       tdm_byte,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [15:0]      tx_data,
    output logic             tx_soc,
    output logic             tx_par,
    output logic             tx_overrun
);

    logic [1:0][IDXW-1:0] rd_addr;
    logic [1:0][7:0]      rd_byte;
    logic                 blk_rdy;
    logic                 rel;

    aal1_pp_buf #(.BLK_BYTES(BLK_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (cfg_enable),
        .wr_vld_i  (tdm_valid),
        .wr_byte_i (tdm_byte),
        .rd_addr_i (rd_addr),
        .rd_byte_o (rd_byte),
        .blk_rdy_o (blk_rdy),
        .rel_i     (rel),
        .ovr_o     (tx_overrun)
    );

    aal1_cell_tx #(.BLK_BYTES(BLK_BYTES), .HDR_BYTES(HDR_BYTES)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (cfg_enable),
        .hdr_i      (cfg_hdr),
        .blk_rdy_i  (blk_rdy),
        .rd_addr_o  (rd_addr),
        .rd_byte_i  (rd_byte),
        .rel_o      (rel),
        .tx_ready_i (tx_ready),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data),
        .tx_soc_o   (tx_soc),
        .tx_par_o   (tx_par)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !tx_valid && !tx_overrun);

endmodule

// File: tb/aal1_udt_segmenter_tb.sv
`timescale 1ns/1ps
module aal1_udt_segmenter_tb;

    localparam logic [47:0] HDR_CFG = 48'hA1B2_C3D4_E5F6;
    // Expected AAL1 header byte per sequence count (R4)
    localparam logic [7:0] AAL1_EXP [8] = '{8'h00, 8'h17, 8'h2D, 8'h3A,
                                            8'h4E, 8'h59, 8'h63, 8'h74};
    // Stimulus phases: {ready mode, idle cycles between bytes, blocks}
    localparam int NPH = 3;
    localparam int PH_TAB [NPH][3] = '{'{0, 0, 6}, '{1, 1, 8}, '{1, 0, 8}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0;
    logic tdm_valid = 1'b0;
    logic [7:0] tdm_byte = 8'h00;
    logic tx_ready = 1'b0;
    logic tx_valid, tx_soc, tx_par, tx_overrun;
    logic [15:0] tx_data;

    always #2.5 clk = ~clk;

    aal1_udt_segmenter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_hdr(HDR_CFG),
        .tdm_valid(tdm_valid), .tdm_byte(tdm_byte), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_soc(tx_soc),
        .tx_par(tx_par), .tx_overrun(tx_overrun)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cells = 0;
    int ovr_seen = 0;
    int rmode = 0;
    int rcnt = 0;
    logic [2:0] exp_seq = 3'd0;
    logic [7:0] exp_pay = 8'h00;
    logic [7:0] ramp = 8'h00;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ready pattern
    always begin
        @(posedge clk);
        #1;
        rcnt++;
        case (rmode)
            0:       tx_ready = 1'b1;
            1:       tx_ready = (rcnt % 3) != 0;
            default: tx_ready = 1'b0;
        endcase
    end

    // output monitor
    int wcnt = 0;
    logic [7:0] cb [54];
    bit pstall = 1'b0;
    logic [15:0] pdata;
    logic psoc, ppar;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_overrun) ovr_seen++;
            if (pstall)
                chk(tx_valid && tx_data == pdata && tx_soc == psoc && tx_par == ppar,
                    "R8", {tx_valid, tx_data}, {1'b1, pdata});
            pstall = tx_valid && !tx_ready;
            pdata = tx_data; psoc = tx_soc; ppar = tx_par;
            if (tx_valid && tx_ready) begin
                chk(tx_soc == (wcnt == 0), "R6", tx_soc, wcnt == 0);
                chk(^{tx_data, tx_par} == 1'b1, "R7", tx_par, ~^tx_data);
                cb[2*wcnt] = tx_data[15:8];
                cb[2*wcnt+1] = tx_data[7:0];
                wcnt++;
                if (wcnt == 27) begin
                    wcnt = 0;
                    for (int i = 0; i < 6; i++)
                        chk(cb[i] == HDR_CFG[8*(5-i) +: 8], "R3", cb[i], HDR_CFG[8*(5-i) +: 8]);
                    chk(cb[6][6:4] == exp_seq, "R5", cb[6][6:4], exp_seq);
                    chk(cb[6] == AAL1_EXP[exp_seq], "R4", cb[6], AAL1_EXP[exp_seq]);
                    for (int i = 7; i < 54; i++) begin
                        chk(cb[i] == exp_pay, "R2", cb[i], exp_pay);
                        exp_pay++;
                    end
                    exp_seq++;
                    cells++;
                end
            end
        end
    end

    task automatic push(input logic [7:0] v, input int gap);
        @(posedge clk); #1;
        tdm_valid = 1'b1; tdm_byte = v;
        for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
            tdm_valid = 1'b0;
        end
    endtask

    task automatic push_ramp(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            push(ramp, gap);
            ramp++;
        end
    endtask

    task automatic stop_feed();
        @(posedge clk); #1;
        tdm_valid = 1'b0;
    endtask

    task automatic wait_cells(input int n);
        while (cells < n && !done) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cells expected completion", cells);
        summary();
    end

    initial begin
        int target;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!tx_valid && !tx_overrun, "R1", {tx_valid, tx_overrun}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !tx_overrun, "R1", {tx_valid, tx_overrun}, 0);
        cfg_enable = 1'b1;

        // table-driven streaming phases (R2..R7, R9)
        target = 0;
        for (int p = 0; p < NPH; p++) begin
            rmode = PH_TAB[p][0];
            push_ramp(47 * PH_TAB[p][2], PH_TAB[p][1]);
            stop_feed();
            target += PH_TAB[p][2];
            wait_cells(target);
        end
        chk(cells == 22, "R5", cells, 22);
        chk(ovr_seen == 0, "R9", ovr_seen, 0);

        // both banks full: ready held low
        rmode = 2;
        push_ramp(94, 0);
        for (int i = 0; i < 47; i++) push(8'hEE, 0);
        stop_feed();
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(ovr_seen == 47, "R9", ovr_seen, 47);
        chk(cells == 22 && tx_valid && tx_soc, "R8", cells, 22);
        rmode = 0;
        wait_cells(24);
        repeat (5) @(negedge clk);
        chk(ovr_seen == 47, "R9", ovr_seen, 47);

        // disable: partial block discarded, seq reset (R10)
        for (int i = 0; i < 20; i++) push(8'hEE, 0);
        stop_feed();
        @(posedge clk); #1;
        cfg_enable = 1'b0;
        exp_seq = 3'd0;
        for (int i = 0; i < 60; i++) push(8'hEE, 0);
        stop_feed();
        repeat (3) @(negedge clk);
        chk(!tx_valid && cells == 24, "R10", {tx_valid, cells}, 24);
        @(posedge clk); #1;
        cfg_enable = 1'b1;
        push_ramp(94, 0);
        stop_feed();
        wait_cells(26);
        chk(cells == 26 && exp_seq == 3'd2, "R10", exp_seq, 2);

        done = 1'b1;
        summary();
    end

endmodule